// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits directly on a 4-bit media-independent receive interface. On every clock it samples one nibble, qualified by a receive-data-valid line. It waits for a valid preamble and start-of-frame delimiter, then rebuilds bytes from nibble pairs. Each destination address is compared against a programmed station address and against the broadcast address. Every accepted frame is passed downstream as a byte stream with start and end markers, and it closes with a single status word. That word carries the CRC verdict, the short-frame and over-length flags, and the kind of address match.

Frames are not buffered. The block holds the first six bytes in a short delay line until the address decision is known. Bytes then leave at the input rate. When receive-data-valid drops, the last six bytes drain at one per cycle. Frames with a bad header or a foreign destination leave no trace at the output. The block is expected to see the usual inter-frame gap, which is far longer than the six-cycle drain. A global enable starts processing at once when it is set, and clears all frame state when it is cleared.

Top module: `rx_frame_checker`

## Requirements
- R1: While `enable` is low, no byte and no status is produced and any frame in progress is abandoned. The first frame whose header starts after `enable` rises is processed normally.
- R2: A frame header is valid only if receive-data-valid rises on a run of one or more 0x5 nibbles, followed by the delimiter byte 0xD5 (nibble 0x5, then nibble 0xD). Any other nibble before the delimiter drops the whole frame: no bytes and no status.
- R3: Bytes are rebuilt low nibble first. The forwarded stream is every byte from the first destination byte through the last FCS byte, in order. `out_sof` marks the first byte and `out_eof` marks the last.
- R4: Frame bytes 0..5 are the destination, with byte 0 compared against `station_addr[47:40]`. A frame is accepted if the destination equals `station_addr` or is all 0xFF. A frame that matches neither, or that ends before six bytes, is dropped without output or status.
- R5: `stat_crc_err` is 0 only when the last four bytes hold the complement of the CRC-32 computed over all earlier bytes. That CRC uses polynomial 0x04C11DB7, reflected, with initial value all ones, each byte taken LSB first, and the FCS sent low byte first. This is detected as the residue 0xC704DD7B, in bit-reversed form, over data plus FCS.
- R6: `stat_short` is 1 when the byte count, from the destination through the FCS, is below `MIN_LEN` (64).
- R7: `stat_long` is 1 when that byte count is greater than `max_len`. A count equal to `max_len` is not flagged.
- R8: `stat_valid` pulses exactly once per accepted frame, in the same cycle as `out_eof`. `stat_bcast` is 1 when the match came from the broadcast address and 0 when it came from the station address.
- R9: The CRC and length verdicts are independent. Any combination of them is reported together in the one status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one nibble per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global receive enable |
| mii_dv | input | 1 | Receive data valid |
| mii_rxd | input | 4 | Receive nibble |
| station_addr | input | 48 | Station address, first transmitted byte in bits 47:40 |
| max_len | input | LEN_W | Maximum frame length in bytes |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| stat_valid | output | 1 | Status word valid |
| stat_crc_err | output | 1 | CRC check failed |
| stat_short | output | 1 | Frame below minimum length |
| stat_long | output | 1 | Frame above `max_len` |
| stat_bcast | output | 1 | Accepted through the broadcast address |

## Verification
The CRC verdict and the length verdicts are computed in the same end-of-frame cycle and land in one status word. Two frames provoke this overlap: a short frame with a byte corrupted after its FCS was computed, and an over-length frame damaged the same way. Each flag of the status word is compared separately with the value predicted from the bench's own byte count and CRC, so a lost or swapped flag is caught. Length boundaries are probed on both sides: 63 and 64 bytes for the short check, and `max_len` and `max_len`+1 for the long check.

// File: rtl/rx_frame_checker.sv
module rx_frame_checker #(
  parameter int MIN_LEN = 64,
  parameter int LEN_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mii_dv,
  input  logic [3:0]       mii_rxd,
  input  logic [47:0]      station_addr,
  input  logic [LEN_W-1:0] max_len,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic             stat_valid,
  output logic             stat_crc_err,
  output logic             stat_short,
  output logic             stat_long,
  output logic             stat_bcast
);

  localparam int          DA_BYTES = 6;
  localparam logic [2:0]  DLY_FULL = 3'(DA_BYTES);
  localparam logic [31:0] POLY     = 32'hEDB88320;
  localparam logic [31:0] RESIDUE  = 32'hDEBB20E3;

  typedef enum logic [2:0] {S_IDLE, S_PRE1, S_PRE2, S_DATA, S_DROP} rx_state_t;

  rx_state_t        st;
  logic             half, first, draining;
  logic [3:0]       lo;
  logic [LEN_W-1:0] nbytes;
  logic [31:0]      crc;
  logic             sta_ok, bc_ok;
  logic [47:0]      dly;
  logic [2:0]       cnt;
  logic             f_crc, f_short, f_long, f_bc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? POLY : 32'h0);
    return r;
  endfunction

  wire        byte_stb  = enable && st == S_DATA && mii_dv && half;
  wire        frame_end = enable && st == S_DATA && !mii_dv;
  wire [7:0]  rx_byte   = {mii_rxd, lo};
  wire        accepted  = sta_ok | bc_ok;
  wire        da_done   = nbytes >= LEN_W'(DA_BYTES);
  wire [47:0] sta_sh    = station_addr << {nbytes[2:0], 3'b000};
  wire [47:0] dly_sh    = dly >> {cnt - 3'd1, 3'b000};

  assign stat_crc_err = stat_valid & f_crc;
  assign stat_short   = stat_valid & f_short;
  assign stat_long    = stat_valid & f_long;
  assign stat_bcast   = stat_valid & f_bc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      half <= 1'b0; first <= 1'b0; draining <= 1'b0;
      lo <= '0; nbytes <= '0; crc <= '1;
      sta_ok <= 1'b0; bc_ok <= 1'b0;
      dly <= '0; cnt <= '0;
      f_crc <= 1'b0; f_short <= 1'b0; f_long <= 1'b0; f_bc <= 1'b0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0;
      stat_valid <= 1'b0;
    end else begin
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      stat_valid <= 1'b0;
      if (!enable) begin
        st       <= S_IDLE;
        half     <= 1'b0;
        draining <= 1'b0;
        cnt      <= '0;
      end else begin
        case (st)
          S_IDLE: if (mii_dv) st <= (mii_rxd == 4'h5) ? S_PRE1 : S_DROP;
          S_PRE1: if (!mii_dv) st <= S_IDLE;
                  else st <= (mii_rxd == 4'h5) ? S_PRE2 : S_DROP;
          S_PRE2: if (!mii_dv) st <= S_IDLE;
                  else if (mii_rxd == 4'hD) begin
                    st     <= S_DATA;
                    half   <= 1'b0;
                    nbytes <= '0;
                    crc    <= '1;
                    sta_ok <= 1'b1;
                    bc_ok  <= 1'b1;
                    first  <= 1'b1;
                  end else if (mii_rxd != 4'h5) st <= S_DROP;
          S_DATA: if (!mii_dv) st <= S_IDLE;
                  else begin
                    half <= ~half;
                    if (!half) lo <= mii_rxd;
                  end
          S_DROP: if (!mii_dv) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase

        if (byte_stb) begin
          crc <= crc_step(crc, rx_byte);
          if (nbytes != '1) nbytes <= nbytes + 1'b1;
          if (!da_done) begin
            sta_ok <= sta_ok & (rx_byte == sta_sh[47:40]);
            bc_ok  <= bc_ok & (rx_byte == 8'hFF);
          end
          dly <= {dly[39:0], rx_byte};
          if (cnt != DLY_FULL) cnt <= cnt + 3'd1;
          else if (accepted) begin
            out_valid <= 1'b1;
            out_data  <= dly[47:40];
            out_sof   <= first;
            first     <= 1'b0;
          end
        end

        if (frame_end) begin
          if (da_done && accepted) begin
            draining <= 1'b1;
            f_crc    <= crc != RESIDUE;
            f_short  <= nbytes < LEN_W'(MIN_LEN);
            f_long   <= nbytes > max_len;
            f_bc     <= bc_ok;
          end else begin
            cnt <= '0;
          end
        end

        if (draining) begin
          out_valid <= 1'b1;
          out_data  <= dly_sh[7:0];
          out_sof   <= first;
          first     <= 1'b0;
          cnt       <= cnt - 3'd1;
          if (cnt == 3'd1) begin
            draining   <= 1'b0;
            out_eof    <= 1'b1;
            stat_valid <= 1'b1;
          end
        end
      end
    end
  end

endmodule

module rx_frame_checker_sva #(
  parameter int MIN_LEN = 64,
  parameter int LEN_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [LEN_W-1:0] max_len,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_eof,
  input logic             stat_valid,
  input logic             stat_short,
  input logic             stat_long
);

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!out_valid && !stat_valid));

  assert_sof_is_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  assert_status_on_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> (out_valid && out_eof));

  assert_last_has_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> stat_valid);

  assert_len_flags_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && max_len >= LEN_W'(MIN_LEN)) |-> !(stat_short && stat_long));

endmodule

bind rx_frame_checker rx_frame_checker_sva #(.MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable), .max_len(max_len),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .stat_valid(stat_valid), .stat_short(stat_short), .stat_long(stat_long)
);

// File: tb/tb_rx_frame_checker.sv
module tb_rx_frame_checker;
  localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] BC  = 48'hFFFFFFFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        mii_dv = 1'b0;
  logic [3:0]  mii_rxd = 4'h0;
  logic [47:0] station_addr = STA;
  logic [15:0] max_len = 16'd1518;
  logic        out_valid, out_sof, out_eof, stat_valid;
  logic [7:0]  out_data;
  logic        stat_crc_err, stat_short, stat_long, stat_bcast;

  always #10 clk = ~clk;

  rx_frame_checker dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mii_dv(mii_dv), .mii_rxd(mii_rxd),
    .station_addr(station_addr), .max_len(max_len),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .stat_valid(stat_valid), .stat_crc_err(stat_crc_err), .stat_short(stat_short),
    .stat_long(stat_long), .stat_bcast(stat_bcast)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] fr  [0:2047];
  logic [7:0] cap [0:2047];
  int fr_len = 0;
  int cap_n = 0, sof_n = 0, st_n = 0, sof_pos = -1, eof_pos = -1;
  logic s_crc = 0, s_short = 0, s_long = 0, s_bc = 0;

  always @(negedge clk) begin
    if (out_valid && cap_n < 2048) begin
      cap[cap_n] = out_data;
      if (out_sof) begin sof_n++; sof_pos = cap_n; end
      if (out_eof) eof_pos = cap_n;
      cap_n++;
    end
    if (stat_valid) begin
      st_n++;
      s_crc = stat_crc_err; s_short = stat_short; s_long = stat_long; s_bc = stat_bcast;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap_n = 0; sof_n = 0; st_n = 0; sof_pos = -1; eof_pos = -1;
  endtask

  function automatic logic [31:0] crc32(input int n);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ fr[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  task automatic build(input logic [47:0] da, input int len);
    logic [31:0] fcs;
    for (int i = 0; i < len; i++) begin
      if (i < 6) fr[i] = da[47 - 8*i -: 8];
      else if (i < 12) fr[i] = 8'(8'h02 + i);
      else fr[i] = 8'(i * 7 + 3);
    end
    fr_len = len;
    if (len >= 10) begin
      fcs = ~crc32(len - 4);
      fr[len-4] = fcs[7:0];   fr[len-3] = fcs[15:8];
      fr[len-2] = fcs[23:16]; fr[len-1] = fcs[31:24];
    end
  endtask

  task automatic send(input int pre_n, input logic [3:0] pre_nib, input logic [7:0] sfd);
    clear_mon();
    for (int i = 0; i < pre_n; i++) begin
      @(negedge clk); mii_dv = 1'b1; mii_rxd = pre_nib;
    end
    @(negedge clk); mii_dv = 1'b1; mii_rxd = sfd[3:0];
    @(negedge clk); mii_rxd = sfd[7:4];
    for (int i = 0; i < fr_len; i++) begin
      @(negedge clk); mii_rxd = fr[i][3:0];
      @(negedge clk); mii_rxd = fr[i][7:4];
    end
    @(negedge clk); mii_dv = 1'b0; mii_rxd = 4'h0;
    repeat (30) @(negedge clk);
  endtask

  task automatic expect_frame(input string req, input bit bc, input bit ce,
                              input bit sh, input bit lg);
    int mis;
    mis = 0;
    for (int i = 0; i < fr_len; i++) if (cap[i] !== fr[i]) mis++;
    chk(cap_n == fr_len, req, "byte count", cap_n, fr_len);
    chk(mis == 0, req, "byte mismatches", mis, 0);
    chk(sof_n == 1 && sof_pos == 0, req, "sof position", sof_pos, 0);
    chk(eof_pos == fr_len - 1, req, "eof position", eof_pos, fr_len - 1);
    chk(st_n == 1, req, "status count", st_n, 1);
    chk(s_bc == bc, req, "bcast flag", s_bc, bc);
    chk(s_crc == ce, req, "crc flag", s_crc, ce);
    chk(s_short == sh, req, "short flag", s_short, sh);
    chk(s_long == lg, req, "long flag", s_long, lg);
  endtask

  task automatic expect_none(input string req);
    chk(cap_n == 0, req, "bytes out on dropped frame", cap_n, 0);
    chk(st_n == 0, req, "status on dropped frame", st_n, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 0 && stat_valid == 0, "R1", "reset outputs", {out_valid, stat_valid}, 0);
  endtask

  task automatic t_station();
    build(STA, 64); send(7, 4'h5, 8'hD5);
    expect_frame("R3", 0, 0, 0, 0);
  endtask

  task automatic t_bcast();
    build(BC, 80); send(7, 4'h5, 8'hD5);
    expect_frame("R8", 1, 0, 0, 0);
  endtask

  task automatic t_mismatch();
    build(48'h0A1B2C3D4E5E, 64); send(7, 4'h5, 8'hD5);
    expect_none("R4");
    build(BC, 5); send(7, 4'h5, 8'hD5);
    expect_none("R4");
  endtask

  task automatic t_header();
    build(STA, 64);
    send(7, 4'h5, 8'hD4); expect_none("R2");
    send(0, 4'h5, 8'hD5); expect_none("R2");
    send(7, 4'h4, 8'hD5); expect_none("R2");
    send(1, 4'h5, 8'hD5); expect_frame("R2", 0, 0, 0, 0);
  endtask

  task automatic t_crc();
    build(STA, 70); fr[20] = fr[20] ^ 8'h01; send(7, 4'h5, 8'hD5);
    expect_frame("R5", 0, 1, 0, 0);
  endtask

  task automatic t_short();
    build(STA, 63); send(7, 4'h5, 8'hD5);
    expect_frame("R6", 0, 0, 1, 0);
    build(BC, 40); send(7, 4'h5, 8'hD5);
    expect_frame("R6", 1, 0, 1, 0);
  endtask

  task automatic t_long();
    max_len = 16'd100;
    build(STA, 101); send(7, 4'h5, 8'hD5);
    expect_frame("R7", 0, 0, 0, 1);
    build(STA, 100); send(7, 4'h5, 8'hD5);
    expect_frame("R7", 0, 0, 0, 0);
    max_len = 16'd1518;
  endtask

  task automatic t_combo();
    build(STA, 50); fr[30] = fr[30] ^ 8'h80; send(7, 4'h5, 8'hD5);
    expect_frame("R9", 0, 1, 1, 0);
    max_len = 16'd90;
    build(BC, 120); fr[60] = fr[60] ^ 8'h10; send(7, 4'h5, 8'hD5);
    expect_frame("R9", 1, 1, 0, 1);
    max_len = 16'd1518;
  endtask

  task automatic t_enable();
    enable = 1'b0;
    build(STA, 64); send(7, 4'h5, 8'hD5);
    expect_none("R1");
    enable = 1'b1;
    send(7, 4'h5, 8'hD5);
    expect_frame("R1", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_station();
    t_bcast();
    t_mismatch();
    t_header();
    t_crc();
    t_short();
    t_long();
    t_combo();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule